// File: doc/BRIEF.md
# Multi-Core Operand Staging Controller

This block sits between a host register interface and a set of small matrix-multiply cores. The host fills a separate staging store for each core, one element per write. Each write names the operand (A or B), the target core, a row, a column and an 8-bit value. A single start pulse then copies every core's staged operands into that core's local scratchpads. The copy runs for all cores in parallel, one element index per cycle. The controller then launches all cores in one cycle and waits until each of them has reported completion. Only then does it raise done.

While done is high, the host reads results by core and by row and column, one element per read pulse. The staged data stays in place after a run, so a later run can reuse it. The host only needs to rewrite the elements that change. The compute cores are simple stubs. Each stub forms C = A x B over unsigned operands, and core i adds a tail of i x LAT_STEP cycles before it signals completion. This makes the cores finish at different times, so the completion barrier does real work.

Top module: `mcs_ctrl`

## Requirements
- R1: After reset, busy and done are 0 and rd_data is 0.
- R2: A write pulse with wr_bank=0 stores wr_data as A[wr_row][wr_col] of core wr_core, and wr_bank=1 stores it as B. After a run, result element C[i][j] of a core equals the 32-bit sum over k of A[i][k]*B[k][j], with unsigned operands.
- R3: Each core's results depend only on that core's own staged A and B. A write to one core never changes another core's results.
- R4: busy is 1 from the cycle after an accepted start until done rises. busy and done are never 1 together.
- R5: A start pulse received while busy is ignored. The run in progress is not restarted and its timing does not change.
- R6: All staged elements are copied into every core's scratchpads before any core starts computing.
- R7: Every core receives its launch in the same cycle.
- R8: done rises only after every core has reported completion. With default parameters it first appears 2*16+3+(2-1)*20 = 55 cycles after the start is sampled. Each core's one-cycle completion is held in a sticky flag until the barrier clears. done stays 1 until the next accepted start.
- R9: A read pulse while done is 1 loads rd_data with C[rd_row][rd_col] of core rd_core on the next clock. A read pulse while done is 0 leaves rd_data unchanged.
- R10: Staged data persists across runs. A second start with no new writes gives the same results. Rewriting one element changes only the results that use that element.
- R11: A write pulse while busy is ignored and does not alter staged data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Operand write pulse |
| wr_bank | input | 1 | Operand select: 0 = A, 1 = B |
| wr_core | input | CORE_W | Target core of the write |
| wr_row | input | POS_W | Row index of the write |
| wr_col | input | POS_W | Column index of the write |
| wr_data | input | DATA_W | Operand value |
| start | input | 1 | Run start pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | All cores finished; results readable |
| rd_en | input | 1 | Result read pulse |
| rd_core | input | CORE_W | Core selected for readback |
| rd_row | input | POS_W | Result row |
| rd_col | input | POS_W | Result column |
| rd_data | output | ACC_W | Registered result element |

## Verification
The assertions assume that the control inputs are clean single-cycle pulses. They also assume that wr_core and rd_core name an existing core, and that the tile edge is a power of two, so that the element walk counter wraps exactly at the last element. The bench changes every input only on the falling clock edge and only addresses cores 0 and 1 of the default build. During a run, its only stimulus is the deliberate start pulse and write pulse that check that both are ignored.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LAUNCH,
    ST_WAIT,
    ST_DONE
  } ctrl_st_e;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_CALC,
    CS_TAIL
  } core_st_e;
endpackage

// File: rtl/mcs_stage_bank.sv
module mcs_stage_bank #(
  parameter int TILE   = 4,
  parameter int DATA_W = 8,
  localparam int ELEMS = TILE * TILE,
  localparam int IDX_W = $clog2(ELEMS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              sel_b,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q
);
  logic [DATA_W-1:0] a_mem [ELEMS];
  logic [DATA_W-1:0] b_mem [ELEMS];

  always_ff @(posedge clk) begin
    if (we && !sel_b) a_mem[wr_idx] <= wr_data;
    if (we && sel_b)  b_mem[wr_idx] <= wr_data;
  end

  assign a_q = a_mem[rd_idx];
  assign b_q = b_mem[rd_idx];
endmodule

// File: rtl/mcs_core_stub.sv
module mcs_core_stub
  import mcs_pkg::*;
#(
  parameter int TILE     = 4,
  parameter int DATA_W   = 8,
  parameter int ACC_W    = 32,
  parameter int TAIL_CYC = 0,
  localparam int ELEMS = TILE * TILE,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int TW    = (TAIL_CYC > 0) ? $clog2(TAIL_CYC + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_a,
  input  logic [DATA_W-1:0] ld_b,
  input  logic              launch,
  output logic              act,
  output logic              fin,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ACC_W-1:0]  rd_q
);
  logic [DATA_W-1:0] a_mem [ELEMS];
  logic [DATA_W-1:0] b_mem [ELEMS];
  logic [ACC_W-1:0]  c_mem [ELEMS];

  core_st_e         st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [TW-1:0]    tail_q, tail_d;
  logic             fin_d;
  logic [ACC_W-1:0] dot;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      a_mem[ld_idx] <= ld_a;
      b_mem[ld_idx] <= ld_b;
    end
    if (st_q == CS_CALC) c_mem[cnt_q] <= dot;
  end

  // one output element per cycle, row-major
  always_comb begin
    int r, c;
    r   = int'(cnt_q) / TILE;
    c   = int'(cnt_q) % TILE;
    dot = '0;
    for (int k = 0; k < TILE; k++)
      dot = dot + ACC_W'(a_mem[IDX_W'(r * TILE + k)]) * ACC_W'(b_mem[IDX_W'(k * TILE + c)]);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tail_d = tail_q;
    fin_d  = 1'b0;
    case (st_q)
      CS_IDLE: if (launch) begin
        st_d  = CS_CALC;
        cnt_d = '0;
      end
      CS_CALC: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == IDX_W'(ELEMS - 1)) begin
          st_d   = CS_TAIL;
          tail_d = TW'(TAIL_CYC);
        end
      end
      CS_TAIL: begin
        if (tail_q == '0) begin
          fin_d = 1'b1;
          st_d  = CS_IDLE;
        end else begin
          tail_d = tail_q - 1'b1;
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      cnt_q  <= '0;
      tail_q <= '0;
      fin    <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
      fin    <= fin_d;
    end
  end

  assign act  = (st_q != CS_IDLE);
  assign rd_q = c_mem[rd_idx];

  // R6: scratchpads are never reloaded under a running computation
  a_r6_no_load_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> (st_q == CS_IDLE));
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
#(
  parameter int N_CORES  = 2,
  parameter int TILE     = 4,
  parameter int DATA_W   = 8,
  parameter int ACC_W    = 32,
  parameter int LAT_STEP = 20,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int POS_W  = (TILE > 1) ? $clog2(TILE) : 1,
  localparam int ELEMS  = TILE * TILE,
  localparam int IDX_W  = $clog2(ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [CORE_W-1:0] wr_core,
  input  logic [POS_W-1:0]  wr_row,
  input  logic [POS_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              rd_en,
  input  logic [CORE_W-1:0] rd_core,
  input  logic [POS_W-1:0]  rd_row,
  input  logic [POS_W-1:0]  rd_col,
  output logic [ACC_W-1:0]  rd_data
);
  // reset asserts at once, releases two edges later
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  ctrl_st_e         st_q, st_d;
  logic [IDX_W-1:0] wk_q;
  logic [N_CORES-1:0] core_act, core_fin, seen_q;
  logic [ACC_W-1:0] core_q [N_CORES];
  logic             accept, launch, all_fin, stage_we;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign busy     = (st_q == ST_LOAD) || (st_q == ST_LAUNCH) || (st_q == ST_WAIT);
  assign done     = (st_q == ST_DONE);
  assign accept   = start && !busy;
  assign launch   = (st_q == ST_LAUNCH);
  assign all_fin  = &(seen_q | core_fin);
  assign stage_we = wr_en && !busy;
  assign wr_idx   = IDX_W'(int'(wr_row) * TILE + int'(wr_col));
  assign rd_idx   = IDX_W'(int'(rd_row) * TILE + int'(rd_col));

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    logic [DATA_W-1:0] sa, sb;

    mcs_stage_bank #(.TILE(TILE), .DATA_W(DATA_W)) u_stage (
      .clk     (clk),
      .we      (stage_we && (wr_core == CORE_W'(g))),
      .sel_b   (wr_bank),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (wk_q),
      .a_q     (sa),
      .b_q     (sb)
    );

    mcs_core_stub #(
      .TILE(TILE), .DATA_W(DATA_W), .ACC_W(ACC_W), .TAIL_CYC(g * LAT_STEP)
    ) u_core (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .ld_en  (st_q == ST_LOAD),
      .ld_idx (wk_q),
      .ld_a   (sa),
      .ld_b   (sb),
      .launch (launch),
      .act    (core_act[g]),
      .fin    (core_fin[g]),
      .rd_idx (rd_idx),
      .rd_q   (core_q[g])
    );

    // sticky completion: cleared by launch, set by the core's pulse
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)         seen_q[g] <= 1'b0;
      else if (launch)      seen_q[g] <= 1'b0;
      else if (core_fin[g]) seen_q[g] <= 1'b1;
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_DONE: if (start) st_d = ST_LOAD;
      ST_LOAD:   if (wk_q == IDX_W'(ELEMS - 1)) st_d = ST_LAUNCH;
      ST_LAUNCH: st_d = ST_WAIT;
      ST_WAIT:   if (all_fin) st_d = ST_DONE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q    <= ST_IDLE;
      wk_q    <= '0;
      rd_data <= '0;
    end else begin
      st_q <= st_d;
      if (accept)                wk_q <= '0;
      else if (st_q == ST_LOAD)  wk_q <= wk_q + 1'b1;
      if (rd_en && done)         rd_data <= core_q[rd_core];
    end
  end

  // R4
  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(busy && done));
  a_r4_busy_until_done: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy |=> (busy || done));
  // R5: a start mid-load does not rewind the element walk
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q == ST_LOAD && start) |=> (wk_q == $past(wk_q) + 1'b1));
  // R6
  a_r6_load_before_compute: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q == ST_LOAD) |-> (core_act == '0));
  // R7
  a_r7_common_launch: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q == ST_WAIT && $past(st_q) == ST_LAUNCH) |-> (&core_act));
  // R8
  a_r8_barrier: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(done) |-> (&$past(seen_q | core_fin)));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && !start) |=> done);
  // R9
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!(rd_en && done)) |=> $stable(rd_data));
endmodule

// File: tb/sim_mcs_ctrl.sv
module sim_mcs_ctrl;
  localparam int NC   = 2;
  localparam int T    = 4;
  localparam int E    = T * T;
  localparam int STEP = 20;
  localparam int LAT  = 2 * E + 3 + (NC - 1) * STEP;
  localparam int NV   = 4;
  // seeds per vector: {core0 A, core0 B, core1 A, core1 B}; 00 = identity, FF = all 255
  localparam logic [7:0] SEEDS [NV][4] = '{
    '{8'h00, 8'h03, 8'h05, 8'h00},
    '{8'h11, 8'h27, 8'h35, 8'h4B},
    '{8'hFF, 8'hFF, 8'h00, 8'h00},
    '{8'h09, 8'hFF, 8'h2D, 8'h01}
  };

  logic clk, rst_n;
  logic wr_en, wr_bank, start, rd_en;
  logic [0:0] wr_core, rd_core;
  logic [1:0] wr_row, wr_col, rd_row, rd_col;
  logic [7:0] wr_data;
  logic busy, done;
  logic [31:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  stg  [NC][2][E];
  logic [31:0] expc [NC][E];

  mcs_ctrl #(.N_CORES(NC), .TILE(T), .DATA_W(8), .ACC_W(32), .LAT_STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_core(wr_core),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .start(start),
    .busy(busy), .done(done), .rd_en(rd_en), .rd_core(rd_core),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input logic [7:0] s, input int r, input int c);
    if (s == 8'h00) return (r == c) ? 8'd1 : 8'd0;
    if (s == 8'hFF) return 8'hFF;
    return 8'(int'(s) * (r * 7 + c * 3 + 1));
  endfunction

  function automatic void calc_exp();
    for (int k = 0; k < NC; k++)
      for (int i = 0; i < T; i++)
        for (int j = 0; j < T; j++) begin
          logic [31:0] s;
          s = 0;
          for (int m = 0; m < T; m++)
            s += 32'(stg[k][0][i*T+m]) * 32'(stg[k][1][m*T+j]);
          expc[k][i*T+j] = s;
        end
  endfunction

  task automatic put(input int bank, input int core, input int r, input int c, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = bank[0]; wr_core = core[0];
    wr_row = r[1:0]; wr_col = c[1:0]; wr_data = d;
    stg[core][bank][r*T+c] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // poke: inject a start and an operand write while busy (R5, R11)
  task automatic run(input bit poke);
    int n;
    bit busy_ok;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R4 busy after start", {30'd0, busy, done}, 32'h2);
    n = 0; busy_ok = 1;
    while (done !== 1'b1 && n < 500) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) begin
        start = 1'b1; wr_en = 1'b1; wr_bank = 1'b0; wr_core = 1'b0;
        wr_row = 2'd0; wr_col = 2'd0; wr_data = 8'h77;
      end else begin
        start = 1'b0; wr_en = 1'b0;
      end
      if (done !== 1'b1 && busy !== 1'b1) busy_ok = 0;
    end
    chk(busy_ok, "R4 busy held until done", 32'(busy_ok), 32'd1);
    chk(n == LAT, "R8 done after slowest core", 32'(n), 32'(LAT));
    chk(busy === 1'b0, "R4 busy low with done", 32'(busy), 32'd0);
  endtask

  task automatic rd(input int core, input int r, input int c, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_core = core[0]; rd_row = r[1:0]; rd_col = c[1:0];
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NC; k++)
      for (int i = 0; i < E; i++)
        rd(k, i / T, i % T, expc[k][i], tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; wr_en = 0; wr_bank = 0; wr_core = 0; wr_row = 0; wr_col = 0;
    wr_data = 0; start = 0; rd_en = 0; rd_core = 0; rd_row = 0; rd_col = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(busy === 1'b0, "R1 busy reset", 32'(busy), 32'd0);
    chk(done === 1'b0, "R1 done reset", 32'(done), 32'd0);
    chk(rd_data === 32'd0, "R1 rd_data reset", rd_data, 32'd0);
    // R9: read while not done is ignored
    rd(0, 1, 1, 32'd0, "R9 read ignored when not done");

    // table walk: R2, R3
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < NC; k++)
        for (int b = 0; b < 2; b++)
          for (int i = 0; i < E; i++)
            put(b, k, i / T, i % T, gen(SEEDS[v][k*2+b], i / T, i % T));
      calc_exp();
      run(1'b0);
      check_all("R2 R3 vector result");
    end

    // R8: done stays high with no start
    repeat (10) @(negedge clk);
    chk(done === 1'b1, "R8 done sticky", 32'(done), 32'd1);

    // R10: rerun with no new writes
    run(1'b0);
    check_all("R10 rerun unchanged");

    // R10, R3: one element of core1 A rewritten, core0 must not move
    put(0, 1, 2, 1, 8'hC3);
    calc_exp();
    run(1'b0);
    check_all("R10 R3 single rewrite");

    // R5, R11: start and write during a run are ignored
    run(1'b1);
    check_all("R5 R11 run with busy pokes");
    run(1'b0);
    check_all("R11 staged data untouched");

    // R9: read pulse during a run keeps the last value
    held = rd_data;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    rd(1, 3, 3, held, "R9 read ignored while busy");
    while (done !== 1'b1) @(negedge clk);
    rd(0, 3, 0, expc[0][12], "R9 read after done");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule